// File: doc/BRIEF.md
# Raster timing generator with early fetch strobe

The block produces the raster timing for a video-mode display link. A horizontal pixel counter and a vertical line counter walk through each line and frame in a fixed region order: active area, front porch, sync pulse, back porch. From these counters the block drives horizontal and vertical sync with programmable polarity and a data-enable that is high over the active area. It also drives a one-clock frame interrupt on the first pixel of every frame and a one-clock fetch strobe near the end of the frame, so that an upstream pixel fetch engine can start reading the next frame early.

The fetch position is derived in hardware from a worst-case line budget. Lines that the vertical back porch and sync pulse can absorb are subtracted from the budget. The rest is taken from the vertical front porch, capped at the size of that porch. A running frame pixel counter is compared against the resulting start value. All configuration is written through a small register port into staging registers. Shadow copies of those registers load only while the block is idle or at a frame boundary. A three-state controller sequences the block. ST_IDLE moves to ST_RUN ("start") once the staged enable is set. ST_RUN moves to ST_DRAIN ("stop request") when the enable is cleared in mid-frame, or moves straight to ST_IDLE ("stop at boundary") if the enable is clear on the last pixel. ST_DRAIN returns to ST_RUN ("resume") if the enable is set again, and otherwise moves to ST_IDLE ("drained") at the end of the frame.

Top module: `raster_timer`

## Requirements
- R1: After reset the block is idle. hsync_o, vsync_o, de_o, frame_irq_o and fetch_go_o are all 0, fill_border_o is 0 and fill_underflow_o is 0xFF.
- R2: While running, a frame lasts htot*vtot clocks. htot is the sum of the active width, front porch, sync width and back porch. vtot is the same sum over the vertical fields.
- R3: Each line and each frame starts with the active region, followed by front porch, sync and back porch. de_o is high for exactly hact*vact clocks per frame, starting on the frame's first clock. hsync is active for hsw clocks starting at pixel hact+hfp of every line. vsync is active for vsw whole lines starting at line vact+vfp.
- R4: Polarity bits live in register 0: bit 1 for hsync, bit 2 for vsync. A 1 makes the pulse active-low, which also makes its idle level high.
- R5: While link_is_dsi is 1, both syncs are active-high regardless of the polarity bits.
- R6: The prefetch line count is 0 when vbp+vsw is at least the budget (register 9). Otherwise it is the smaller of vfp and budget-(vbp+vsw).
- R7: The frame pixel count is 1 on the frame's first clock. fetch_go_o pulses for one clock when that count equals (vtot-lines)*htot+1. There is no pulse when the line count is 0 or when fetch enable (register 0 bit 3) is 0.
- R8: fetch_go_o is never high while de_o is high.
- R9: When register 0 bit 4 (split) is 1, four horizontal values are each shifted right by one: active width, sync start (hact+hfp), sync end, and total. Vertical values are unchanged.
- R10: Register writes made in mid-frame do not change the current frame. They take effect from the next frame.
- R11: Clearing enable (register 0 bit 0) in mid-frame lets the current frame finish, including its closing frame interrupt. After that the block stays idle, with no data-enable, no interrupt and no fetch strobe.
- R12: frame_irq_o is a one-clock pulse that coincides with the first pixel of each frame, and it does not occur at any other time in a frame.
- R13: fill_border_o and fill_underflow_o present registers 10 and 11 (register 1..8: hact, hfp, hsw, hbp, vact, vfp, vsw, vbp).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | AW | Register index |
| cfg_wdata | input | DW | Register write data |
| link_is_dsi | input | 1 | Forces active-high syncs |
| hsync_o | output | 1 | Horizontal sync level |
| vsync_o | output | 1 | Vertical sync level |
| de_o | output | 1 | Active-area data enable |
| frame_irq_o | output | 1 | Frame-start interrupt pulse |
| fetch_go_o | output | 1 | Early fetch strobe |
| fill_border_o | output | CW | Border colour setting |
| fill_underflow_o | output | CW | Underflow colour setting |

## Verification
The hardest cases to reach from the ports are those that depend on when a write lands relative to the frame boundary: a stop request arriving in mid-frame, and a geometry change arriving in mid-frame. The stimulus aligns itself to the frame interrupt, issues the write a few clocks later, and then scans the remainder of that frame clock by clock, followed by the next frame or the idle period after it. The three prefetch branches (absorbed, capped by the porch, exact budget) are reached with directed settings. Randomly sized rasters cover the remaining combinations.

// File: rtl/raster_pkg.sv
package raster_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DRAIN} scan_state_t;

    // register indices
    localparam int unsigned A_CTRL   = 0;
    localparam int unsigned A_TF0    = 1;
    localparam int unsigned NUM_TF   = 8;
    localparam int unsigned A_BUDGET = 9;
    localparam int unsigned A_BORDER = 10;
    localparam int unsigned A_UNDER  = 11;

    // timing field slots
    localparam int unsigned TF_HACT = 0;
    localparam int unsigned TF_HFP  = 1;
    localparam int unsigned TF_HSW  = 2;
    localparam int unsigned TF_HBP  = 3;
    localparam int unsigned TF_VACT = 4;
    localparam int unsigned TF_VFP  = 5;
    localparam int unsigned TF_VSW  = 6;
    localparam int unsigned TF_VBP  = 7;

    // control bits
    localparam int unsigned C_EN    = 0;
    localparam int unsigned C_HPOL  = 1;
    localparam int unsigned C_VPOL  = 2;
    localparam int unsigned C_FETCH = 3;
    localparam int unsigned C_SPLIT = 4;
    localparam int unsigned NUM_CTRL = 5;
endpackage

// File: rtl/raster_regs.sv
module raster_regs
    import raster_pkg::*;
#(
    parameter int unsigned DW = 32,
    parameter int unsigned AW = 4,
    parameter int unsigned TW = 12,
    parameter int unsigned CW = 24
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [AW-1:0]            addr,
    input  logic [DW-1:0]            wdata,
    input  logic                     load,
    output logic                     stg_en,
    output logic [NUM_CTRL-1:0]      ctrl_s,
    output logic [NUM_TF-1:0][TW-1:0] tf_s,
    output logic [TW-1:0]            budget_s,
    output logic [CW-1:0]            border_s,
    output logic [CW-1:0]            under_s
);
    localparam logic [CW-1:0] UNDER_RST = CW'(8'hFF);

    logic [NUM_CTRL-1:0] ctrl_q;
    logic [TW-1:0]       budget_q;
    logic [CW-1:0]       border_q;
    logic [CW-1:0]       under_q;
    logic                unused_wdata;

    assign unused_wdata = ^wdata;
    assign stg_en       = ctrl_q[C_EN];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            budget_q <= '0;
            border_q <= '0;
            under_q  <= UNDER_RST;
        end else if (we) begin
            if (addr == AW'(A_CTRL))   ctrl_q   <= wdata[NUM_CTRL-1:0];
            if (addr == AW'(A_BUDGET)) budget_q <= wdata[TW-1:0];
            if (addr == AW'(A_BORDER)) border_q <= wdata[CW-1:0];
            if (addr == AW'(A_UNDER))  under_q  <= wdata[CW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_s   <= '0;
            budget_s <= '0;
            border_s <= '0;
            under_s  <= UNDER_RST;
        end else if (load) begin
            ctrl_s   <= ctrl_q;
            budget_s <= budget_q;
            border_s <= border_q;
            under_s  <= under_q;
        end
    end

    for (genvar k = 0; k < NUM_TF; k++) begin : g_tf
        logic [TW-1:0] stg_q;
        logic [TW-1:0] sh_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stg_q <= '0;
                sh_q  <= '0;
            end else begin
                if (we && addr == AW'(A_TF0 + k)) stg_q <= wdata[TW-1:0];
                if (load) sh_q <= stg_q;
            end
        end
        assign tf_s[k] = sh_q;
    end
endmodule

// File: rtl/raster_geom.sv
module raster_geom
    import raster_pkg::*;
#(
    parameter int unsigned TW  = 12,
    parameter int unsigned HCW = TW + 2,
    parameter int unsigned VCW = TW + 2,
    parameter int unsigned FCW = HCW + VCW
) (
    input  logic [NUM_TF-1:0][TW-1:0] tf,
    input  logic [TW-1:0]             budget,
    input  logic                      split,
    input  logic                      fetch_en,
    output logic [HCW-1:0]            hact_e,
    output logic [HCW-1:0]            hss_e,
    output logic [HCW-1:0]            hse_e,
    output logic [HCW-1:0]            htot_e,
    output logic [VCW-1:0]            vact_e,
    output logic [VCW-1:0]            vss_e,
    output logic [VCW-1:0]            vse_e,
    output logic [VCW-1:0]            vtot_e,
    output logic [FCW-1:0]            fstart,
    output logic                      fetch_on
);
    logic [HCW-1:0] hss_r, hse_r, htot_r;
    logic [VCW-1:0] sof, bud, vfp, need, lines;

    always_comb begin
        hss_r  = HCW'(tf[TF_HACT]) + HCW'(tf[TF_HFP]);
        hse_r  = hss_r + HCW'(tf[TF_HSW]);
        htot_r = hse_r + HCW'(tf[TF_HBP]);
        if (split) begin
            hact_e = HCW'(tf[TF_HACT]) >> 1;
            hss_e  = hss_r >> 1;
            hse_e  = hse_r >> 1;
            htot_e = htot_r >> 1;
        end else begin
            hact_e = HCW'(tf[TF_HACT]);
            hss_e  = hss_r;
            hse_e  = hse_r;
            htot_e = htot_r;
        end
        vact_e = VCW'(tf[TF_VACT]);
        vfp    = VCW'(tf[TF_VFP]);
        vss_e  = vact_e + vfp;
        vse_e  = vss_e + VCW'(tf[TF_VSW]);
        vtot_e = vse_e + VCW'(tf[TF_VBP]);

        // prefetch lines left after back porch and sync absorb their share
        sof  = VCW'(tf[TF_VBP]) + VCW'(tf[TF_VSW]);
        bud  = VCW'(budget);
        need = bud - sof;
        if (sof >= bud)     lines = '0;
        else if (vfp < need) lines = vfp;
        else                 lines = need;

        fstart   = FCW'(vtot_e - lines) * FCW'(htot_e) + FCW'(1);
        fetch_on = fetch_en && (lines != '0);
    end
endmodule

// File: rtl/raster_scan.sv
module raster_scan #(
    parameter int unsigned HCW = 14,
    parameter int unsigned VCW = 14,
    parameter int unsigned FCW = HCW + VCW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic [HCW-1:0] htot,
    input  logic [VCW-1:0] vtot,
    output logic [HCW-1:0] h_q,
    output logic [VCW-1:0] v_q,
    output logic [FCW-1:0] fpix_q,
    output logic           at_end
);
    logic line_end;

    assign line_end = (h_q == htot - HCW'(1));
    assign at_end   = run && line_end && (v_q == vtot - VCW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_q    <= '0;
            v_q    <= '0;
            fpix_q <= FCW'(1);
        end else if (!run || at_end) begin
            h_q    <= '0;
            v_q    <= '0;
            fpix_q <= FCW'(1);
        end else begin
            fpix_q <= fpix_q + FCW'(1);
            if (line_end) begin
                h_q <= '0;
                v_q <= v_q + VCW'(1);
            end else begin
                h_q <= h_q + HCW'(1);
            end
        end
    end
endmodule

// File: rtl/raster_timer.sv
module raster_timer
    import raster_pkg::*;
#(
    parameter int unsigned DW = 32,
    parameter int unsigned AW = 4,
    parameter int unsigned TW = 12,
    parameter int unsigned CW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [AW-1:0] cfg_addr,
    input  logic [DW-1:0] cfg_wdata,
    input  logic          link_is_dsi,
    output logic          hsync_o,
    output logic          vsync_o,
    output logic          de_o,
    output logic          frame_irq_o,
    output logic          fetch_go_o,
    output logic [CW-1:0] fill_border_o,
    output logic [CW-1:0] fill_underflow_o
);
    localparam int unsigned HCW = TW + 2;
    localparam int unsigned VCW = TW + 2;
    localparam int unsigned FCW = HCW + VCW;

    scan_state_t state_q, state_d;
    logic                      stg_en, at_end, load, running;
    logic [NUM_CTRL-1:0]       ctrl_s;
    logic [NUM_TF-1:0][TW-1:0] tf_s;
    logic [TW-1:0]             budget_s;
    logic [HCW-1:0]            hact_e, hss_e, hse_e, htot_e, h_q;
    logic [VCW-1:0]            vact_e, vss_e, vse_e, vtot_e, v_q;
    logic [FCW-1:0]            fstart, fpix_q;
    logic                      fetch_on;

    assign running = (state_q != ST_IDLE);
    assign load    = (state_q == ST_IDLE) || at_end;

    raster_regs #(.DW(DW), .AW(AW), .TW(TW), .CW(CW)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .load(load), .stg_en(stg_en), .ctrl_s(ctrl_s), .tf_s(tf_s),
        .budget_s(budget_s), .border_s(fill_border_o), .under_s(fill_underflow_o)
    );

    raster_geom #(.TW(TW), .HCW(HCW), .VCW(VCW), .FCW(FCW)) u_geom (
        .tf(tf_s), .budget(budget_s), .split(ctrl_s[C_SPLIT]), .fetch_en(ctrl_s[C_FETCH]),
        .hact_e(hact_e), .hss_e(hss_e), .hse_e(hse_e), .htot_e(htot_e),
        .vact_e(vact_e), .vss_e(vss_e), .vse_e(vse_e), .vtot_e(vtot_e),
        .fstart(fstart), .fetch_on(fetch_on)
    );

    raster_scan #(.HCW(HCW), .VCW(VCW), .FCW(FCW)) u_scan (
        .clk(clk), .rst_n(rst_n), .run(running), .htot(htot_e), .vtot(vtot_e),
        .h_q(h_q), .v_q(v_q), .fpix_q(fpix_q), .at_end(at_end)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (stg_en) state_d = ST_RUN;                 // start
            ST_RUN:   if (!stg_en) state_d = at_end ? ST_IDLE       // stop at boundary
                                                    : ST_DRAIN;     // stop request
            ST_DRAIN: if (stg_en) state_d = ST_RUN;                 // resume
                      else if (at_end) state_d = ST_IDLE;           // drained
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register and frame interrupt
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            frame_irq_o <= 1'b0;
        end else begin
            state_q     <= state_d;
            frame_irq_o <= at_end;
        end
    end

    // raster outputs
    always_comb begin
        logic hs_act, vs_act;
        hs_act     = running && (h_q >= hss_e) && (h_q < hse_e);
        vs_act     = running && (v_q >= vss_e) && (v_q < vse_e);
        de_o       = running && (h_q < hact_e) && (v_q < vact_e);
        hsync_o    = hs_act ^ (ctrl_s[C_HPOL] & ~link_is_dsi);
        vsync_o    = vs_act ^ (ctrl_s[C_VPOL] & ~link_is_dsi);
        fetch_go_o = running && fetch_on && (fpix_q == fstart);
    end
endmodule

// File: rtl/raster_timer_chk.sv
module raster_timer_chk
    import raster_pkg::*;
#(
    parameter int unsigned HCW = 14,
    parameter int unsigned VCW = 14
) (
    input logic           clk,
    input logic           rst_n,
    input scan_state_t    state,
    input logic [HCW-1:0] h,
    input logic [VCW-1:0] v,
    input logic           de,
    input logic           hs,
    input logic           vs,
    input logic           irq,
    input logic           fetch,
    input logic           dsi
);
    AST_FETCH_OUTSIDE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        fetch |-> !de); // R8
    AST_FETCH_SINGLE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        fetch |=> !fetch); // R7
    AST_IRQ_SINGLE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R12
    AST_IRQ_AT_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (h == '0 && v == '0)); // R12
    AST_DSI_ACTIVE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (dsi && de) |-> (!hs && !vs)); // R5
    AST_IDLE_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && $past(state == ST_IDLE)) |-> !irq); // R11
endmodule

bind raster_timer raster_timer_chk #(.HCW(HCW), .VCW(VCW)) u_chk (
    .clk(clk), .rst_n(rst_n), .state(state_q), .h(h_q), .v(v_q),
    .de(de_o), .hs(hsync_o), .vs(vsync_o), .irq(frame_irq_o),
    .fetch(fetch_go_o), .dsi(link_is_dsi)
);

// File: tb/raster_timer_test.sv
`timescale 1ns/1ps
module raster_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        link_is_dsi = 1'b0;
    logic        hsync_o, vsync_o, de_o, frame_irq_o, fetch_go_o;
    logic [23:0] fill_border_o, fill_underflow_o;

    int n_checks = 0;
    int n_err = 0;
    int cyc = 0;
    bit done = 0;

    int c_hact, c_hfp, c_hsw, c_hbp, c_vact, c_vfp, c_vsw, c_vbp, c_budget;
    int c_hpol, c_vpol, c_fetch, c_split;

    raster_timer uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .link_is_dsi(link_is_dsi), .hsync_o(hsync_o),
        .vsync_o(vsync_o), .de_o(de_o), .frame_irq_o(frame_irq_o),
        .fetch_go_o(fetch_go_o), .fill_border_o(fill_border_o),
        .fill_underflow_o(fill_underflow_o)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            n_err++;
            $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
            $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
            $finish;
        end
    end

    task automatic check_eq(input string req, input string what, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int ctrl_word(input int en);
        return en | (c_hpol << 1) | (c_vpol << 2) | (c_fetch << 3) | (c_split << 4);
    endfunction

    function automatic int exp_lines();
        int sof = c_vbp + c_vsw;
        if (sof >= c_budget) return 0;
        if (c_vfp < c_budget - sof) return c_vfp;
        return c_budget - sof;
    endfunction

    task automatic wr(input int a, input int d);
        cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = 32'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic apply_cfg();
        wr(1, c_hact); wr(2, c_hfp); wr(3, c_hsw); wr(4, c_hbp);
        wr(5, c_vact); wr(6, c_vfp); wr(7, c_vsw); wr(8, c_vbp);
        wr(9, c_budget); wr(0, ctrl_word(1));
    endtask

    task automatic sync_frame();
        bit seen = 0;
        @(negedge clk);
        for (int i = 0; i < 6000 && !seen; i++) begin
            if (frame_irq_o) seen = 1;
            else @(negedge clk);
        end
        check_eq("R12", "frame interrupt seen", seen, 1);
    endtask

    // scan one frame starting at the interrupt clock; optional write at clock 3
    task automatic measure(input string tag, input bit poke, input int pa, input int pd);
        int ha, hss, hse, ht, vss, vt, lines, fk, flen, hp, vp;
        int n_de, n_hs, n_vs, n_fe, n_irq, f_hs, f_vs, f_fe;
        bit de0;
        ha = c_hact; hss = c_hact + c_hfp; hse = hss + c_hsw; ht = hse + c_hbp;
        if (c_split != 0) begin ha = ha >> 1; hss = hss >> 1; hse = hse >> 1; ht = ht >> 1; end
        vss = c_vact + c_vfp; vt = vss + c_vsw + c_vbp;
        lines = exp_lines();
        fk = (c_fetch != 0 && lines > 0) ? (vt - lines) * ht : -1;
        flen = ht * vt;
        hp = (c_hpol != 0 && !link_is_dsi) ? 1 : 0;
        vp = (c_vpol != 0 && !link_is_dsi) ? 1 : 0;
        n_de = 0; n_hs = 0; n_vs = 0; n_fe = 0; n_irq = 0; f_hs = -1; f_vs = -1; f_fe = -1;
        check_eq({tag, " R12"}, "interrupt at frame start", frame_irq_o, 1);
        de0 = de_o;
        for (int k = 0; k < flen; k++) begin
            if (de_o) n_de++;
            if (hsync_o != hp[0]) begin n_hs++; if (f_hs < 0) f_hs = k; end
            if (vsync_o != vp[0]) begin n_vs++; if (f_vs < 0) f_vs = k; end
            if (fetch_go_o) begin n_fe++; if (f_fe < 0) f_fe = k; end
            if (k > 0 && frame_irq_o) n_irq++;
            if (poke && k == 3) begin cfg_we = 1'b1; cfg_addr = 4'(pa); cfg_wdata = 32'(pd); end
            if (poke && k == 4) cfg_we = 1'b0;
            @(negedge clk);
        end
        check_eq({tag, " R2"}, "interrupt after htot*vtot clocks", frame_irq_o, 1);
        check_eq({tag, " R12"}, "interrupts inside frame", n_irq, 0);
        check_eq({tag, " R3"}, "de on first clock", de0, 1);
        check_eq({tag, " R3"}, "de clocks", n_de, ha * c_vact);
        check_eq({tag, " R3"}, "hsync active clocks", n_hs, (hse - hss) * vt);
        if (hse > hss) check_eq({tag, " R3"}, "hsync first clock", f_hs, hss);
        check_eq({tag, " R3"}, "vsync active clocks", n_vs, c_vsw * ht);
        check_eq({tag, " R3"}, "vsync first clock", f_vs, vss * ht);
        check_eq({tag, " R7"}, "fetch strobes", n_fe, (fk >= 0) ? 1 : 0);
        check_eq({tag, " R6"}, "fetch position", f_fe, fk);
    endtask

    task automatic set_cfg(input int ha, input int hf, input int hw, input int hb,
                           input int va, input int vf, input int vw, input int vb, input int bu);
        c_hact = ha; c_hfp = hf; c_hsw = hw; c_hbp = hb;
        c_vact = va; c_vfp = vf; c_vsw = vw; c_vbp = vb; c_budget = bu;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        c_hpol = 0; c_vpol = 0; c_fetch = 1; c_split = 0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check_eq("R1", "de after reset", de_o, 0);
        check_eq("R1", "hsync after reset", hsync_o, 0);
        check_eq("R1", "vsync after reset", vsync_o, 0);
        check_eq("R1", "irq after reset", frame_irq_o, 0);
        check_eq("R1", "fetch after reset", fetch_go_o, 0);
        check_eq("R1", "border after reset", fill_border_o, 0);
        check_eq("R1", "underflow after reset", fill_underflow_o, 255);
        // R13 colour registers
        wr(10, 32'h123456); wr(11, 32'h00AB00);
        @(negedge clk);
        check_eq("R13", "border colour", fill_border_o, 32'h123456);
        check_eq("R13", "underflow colour", fill_underflow_o, 32'h00AB00);

        // R6 budget fits in front porch: lines = 6-3 = 3
        set_cfg(8, 2, 3, 2, 4, 5, 2, 1, 6);
        apply_cfg(); sync_frame(); measure("R6 exact", 0, 0, 0);
        // R6 front porch too small: lines = vfp = 5
        set_cfg(8, 2, 3, 2, 4, 5, 2, 1, 12);
        apply_cfg(); sync_frame(); measure("R6 capped", 0, 0, 0);
        // R7 budget absorbed: no strobe
        set_cfg(8, 2, 3, 2, 4, 5, 2, 1, 3);
        apply_cfg(); sync_frame(); measure("R7 absorbed", 0, 0, 0);
        // R7 fetch disabled
        c_fetch = 0; set_cfg(8, 2, 3, 2, 4, 5, 2, 1, 6);
        apply_cfg(); sync_frame(); measure("R7 fetch off", 0, 0, 0);
        c_fetch = 1;
        // R4 active-low syncs
        c_hpol = 1; c_vpol = 1;
        apply_cfg(); sync_frame(); measure("R4 low", 0, 0, 0);
        // R5 link forces active-high
        link_is_dsi = 1'b1;
        sync_frame(); measure("R5 dsi", 0, 0, 0);
        link_is_dsi = 1'b0; c_hpol = 0; c_vpol = 0;
        // R9 split halving, odd sums
        c_split = 1; set_cfg(11, 3, 4, 2, 3, 4, 2, 2, 7);
        apply_cfg(); sync_frame(); measure("R9 split", 0, 0, 0);
        c_split = 0;
        // R10 mid-frame write of active width
        set_cfg(10, 2, 2, 3, 4, 3, 1, 2, 5);
        apply_cfg(); sync_frame();
        measure("R10 old frame", 1, 1, 16);
        c_hact = 16;
        measure("R10 new frame", 0, 0, 0);
        // random rasters
        for (int r = 0; r < 8; r++) begin
            set_cfg($urandom_range(20, 2), $urandom_range(6, 1), $urandom_range(4, 1),
                    $urandom_range(6, 1), $urandom_range(8, 2), $urandom_range(6, 1),
                    $urandom_range(3, 1), $urandom_range(3, 0), $urandom_range(12, 0));
            c_hpol = $urandom_range(1, 0); c_vpol = $urandom_range(1, 0);
            c_split = $urandom_range(1, 0); c_fetch = ($urandom_range(3, 0) != 0) ? 1 : 0;
            apply_cfg(); sync_frame(); measure("R2 random", 0, 0, 0);
        end
        // R11 stop request in mid-frame
        c_hpol = 0; c_vpol = 0; c_split = 0; c_fetch = 1;
        set_cfg(8, 2, 3, 2, 4, 5, 2, 1, 6);
        apply_cfg(); sync_frame();
        measure("R11 last frame", 1, 0, ctrl_word(0));
        begin
            int n_de = 0, n_irq = 0, n_fe = 0, n_hs = 0;
            for (int k = 0; k < 3 * 15 * 12; k++) begin
                @(negedge clk);
                if (de_o) n_de++;
                if (frame_irq_o) n_irq++;
                if (fetch_go_o) n_fe++;
                if (hsync_o || vsync_o) n_hs++;
            end
            check_eq("R11", "de while stopped", n_de, 0);
            check_eq("R11", "irq while stopped", n_irq, 0);
            check_eq("R11", "fetch while stopped", n_fe, 0);
            check_eq("R11", "sync activity while stopped", n_hs, 0);
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end
endmodule